// File: doc/BRIEF.md
# Selectable-Interval Timebase Timer

This block keeps a free-running up-counter on the system base clock and raises an interval interrupt request each time the selected counter tap completes a period. A three-bit select code picks one of eight power-of-two periods. The set of periods is not contiguous: codes 0 to 2 give three short periods on adjacent taps, and codes 3 to 7 jump to five long periods on higher adjacent taps. With the default parameters the periods are 2^11, 2^12, 2^13, 2^22, 2^23, 2^24, 2^25 and 2^26 base-clock cycles.

Software writes the select code and an interrupt-enable bit through a small register port and reads them back together with a sticky event flag. The flag is cleared by a separate strobe. A counter-clear input restarts the count at once. A newly written select code is not used straight away. It is taken over at the next period boundary of the code currently in use, or on a counter clear, so a period that is already running is never cut short. Before it enables the interrupt, software must program the select code. The register resets to code 0 so that simulation starts in a known state.

Top module: `tbt_timer`

## Requirements
- R1: After a synchronous reset, `reg_rdata` reads 0 (select code 0, enable 0, flag 0), `irq` is 0 and the counter is 0.
- R2: With code 0, 1 or 2 in use, the flag sets every 2^(LO_FIRST+code) cycles, counted from a counter clear. The defaults are 2^11, 2^12 and 2^13.
- R3: With code c from 3 to 7 in use, the flag sets every 2^(HI_FIRST+c-3) cycles, counted from a counter clear. The defaults are 2^22 to 2^26.
- R4: A cycle with `reg_wr` high stores `reg_wdata[2:0]` as the select code and `reg_wdata[3]` as the interrupt enable. `reg_rdata` presents the flag on bit 4, the enable on bit 3 and the stored select code on bits 2:0.
- R5: A select code written in the middle of a period takes effect only at the end of the period of the code in use, or on a counter clear.
- R6: The flag stays set until `flag_clr` is high at a clock edge, and it is 0 after that edge.
- R7: If `flag_clr` and a period end fall on the same edge, the flag ends up set.
- R8: `irq` is high exactly when the flag is set and the enable is 1. The flag still sets while the enable is 0.
- R9: `cnt_clr` zeroes the counter at the next edge and leaves the flag unchanged. The next period is then counted from that edge.
- R10: The counter wraps through its full range, so the longest period repeats back to back without any software action other than clearing the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System base clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 4 | Write data: bit 3 enable, bits 2:0 select code |
| reg_rdata | output | 5 | Read data: bit 4 flag, bit 3 enable, bits 2:0 select code |
| cnt_clr | input | 1 | Zeroes the counter at the next edge |
| flag_clr | input | 1 | Clears the sticky flag at the next edge |
| irq | output | 1 | Interval interrupt request |

## Verification
A wrong count or a wrong tap shows up only as the flag rising on the wrong cycle. The bench therefore places every expected rise at an exact cycle, counted from a counter clear, and any offset of even one cycle is reported when that rise occurs. A select code that is taken over too early or too late changes which boundary produces the first rise after the write, so the bench picks codes whose boundaries differ in both of those cases. Errors in the flag's priority or stickiness appear within one or two cycles as a missing rise or a wrong bit 4 in the read data.

// File: rtl/tbt_pkg.sv
// Shared types and the code-to-tap mapping of the timebase timer.
// Assumes a three-bit select code: the first LO_CODES codes use adjacent
// low taps and the remaining codes use adjacent taps from a higher base.
package tbt_pkg;
    localparam int SEL_W    = 3;
    localparam int NUM_SEL  = 1 << SEL_W;
    localparam int LO_CODES = 3;

    typedef logic [SEL_W-1:0] tbt_sel_t;

    // Period exponent (log2 of the cycle count) for one select code.
    function automatic int tap_exp(input int code, input int lo_first, input int hi_first);
        return (code < LO_CODES) ? (lo_first + code) : (hi_first + code - LO_CODES);
    endfunction
endpackage

// File: rtl/tbt_counter.sv
// Free-running up-counter on the base clock. It wraps at full range.
// A clear request zeroes it at the next edge, and the clear takes priority
// over counting.
module tbt_counter #(
    parameter int CNT_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    // Count every cycle, or restart from zero on reset or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else               cnt <= cnt + 1'b1;
    end

    assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    assert_counts_and_wraps_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && $past(rst_n)) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
endmodule

// File: rtl/tbt_tap_detect.sv
// Detects a period end for the select code in use: every counter bit
// below that code's tap is one. No period end is reported in a cycle
// that clears the counter. Assumes CNT_W covers the largest tap.
module tbt_tap_detect
    import tbt_pkg::*;
#(
    parameter int CNT_W    = 26,
    parameter int LO_FIRST = 11,
    parameter int HI_FIRST = 22
) (
    input  logic [CNT_W-1:0] cnt,
    input  tbt_sel_t         act_sel,
    input  logic             clr,
    output logic             period_end
);
    logic [NUM_SEL-1:0] tap_hit;

    // One all-ones detector for each selectable tap.
    for (genvar g = 0; g < NUM_SEL; g++) begin : g_tap
        localparam int EXP = tap_exp(g, LO_FIRST, HI_FIRST);
        assign tap_hit[g] = &cnt[EXP-1:0];
    end

    // Pick the detector of the code in use. A counter clear suppresses it.
    always_comb period_end = tap_hit[act_sel] && !clr;
endmodule

// File: rtl/tbt_ctrl.sv
// Control register: the written select code, the interrupt enable, and
// the select code in use. The code in use takes over the written code at
// a period end or on a counter clear.
module tbt_ctrl
    import tbt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     reg_wr,
    input  tbt_sel_t wr_sel,
    input  logic     wr_ie,
    input  logic     period_end,
    input  logic     cnt_clr,
    output tbt_sel_t reg_sel,
    output tbt_sel_t act_sel,
    output logic     ie
);
    // Software-visible fields, loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_sel <= '0;
            ie      <= 1'b0;
        end else if (reg_wr) begin
            reg_sel <= wr_sel;
            ie      <= wr_ie;
        end
    end

    // Code in use, updated only at a period boundary or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)                     act_sel <= '0;
        else if (period_end || cnt_clr) act_sel <= reg_sel;
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr |=> (reg_sel == $past(wr_sel) && ie == $past(wr_ie)));
    assert_sel_held_midperiod_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_end && !cnt_clr && $past(rst_n)) |=> $stable(act_sel));
    assert_sel_taken_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_end || cnt_clr) |=> (act_sel == $past(reg_sel)));
endmodule

// File: rtl/tbt_flag.sv
// Sticky event flag. A period end sets it and a clear strobe clears it.
// When both arrive on the same edge, the set wins.
module tbt_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Hold the flag; set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    assert_clear_works_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag);
    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/tbt_timer.sv
// Top of the timebase timer: a counter, a tap detector, the control register
// and the sticky flag. irq is the flag gated by the enable bit. All reset is
// synchronous and active low.
module tbt_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W    = 26,
    parameter int LO_FIRST = 11,
    parameter int HI_FIRST = 22
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [3:0] reg_wdata,
    output logic [4:0] reg_rdata,
    input  logic       cnt_clr,
    input  logic       flag_clr,
    output logic       irq
);
    logic [CNT_W-1:0] cnt;
    tbt_sel_t         reg_sel;
    tbt_sel_t         act_sel;
    logic             ie;
    logic             period_end;
    logic             flag;

    tbt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .cnt   (cnt)
    );

    tbt_tap_detect #(.CNT_W(CNT_W), .LO_FIRST(LO_FIRST), .HI_FIRST(HI_FIRST)) u_tap (
        .cnt        (cnt),
        .act_sel    (act_sel),
        .clr        (cnt_clr),
        .period_end (period_end)
    );

    tbt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_wr     (reg_wr),
        .wr_sel     (reg_wdata[2:0]),
        .wr_ie      (reg_wdata[3]),
        .period_end (period_end),
        .cnt_clr    (cnt_clr),
        .reg_sel    (reg_sel),
        .act_sel    (act_sel),
        .ie         (ie)
    );

    tbt_flag u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (period_end),
        .clr   (flag_clr),
        .flag  (flag)
    );

    // Read view and the gated interrupt request.
    always_comb begin
        reg_rdata = {flag, ie, reg_sel};
        irq       = flag && ie;
    end

    assert_reset_clean_R1: assert property (@(posedge clk)
        !rst_n |=> (reg_rdata == 5'd0 && !irq && cnt == '0));
    assert_cnt_clr_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_clr && !flag_clr && flag) |=> reg_rdata[4]);
endmodule

// File: tb/tbt_timer_tb.sv
module tbt_timer_tb;
    localparam int CNT_W = 11;
    localparam int LO_F  = 3;
    localparam int HI_F  = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = '0;
    logic [4:0] reg_rdata;
    logic       cnt_clr = 1'b0;
    logic       flag_clr = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int exp_q[$];
    string tag_q[$];
    logic prev_flag = 1'b0;

    tbt_timer #(.CNT_W(CNT_W), .LO_FIRST(LO_F), .HI_FIRST(HI_F)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cnt_clr(cnt_clr), .flag_clr(flag_clr), .irq(irq)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Monitor: each rising edge of the flag pops the next expected cycle.
    always @(negedge clk) begin
        if (rst_n && reg_rdata[4] && !prev_flag && exp_q.size() > 0) begin
            int e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(cyc == e, t, cyc, e);
        end
        prev_flag <= reg_rdata[4];
    end

    function automatic int period(input int code);
        return 1 << ((code < 3) ? (LO_F + code) : (HI_F + code - 3));
    endfunction

    task automatic push(input int c, input string t);
        exp_q.push_back(c);
        tag_q.push_back(t);
    endtask

    task automatic wr(input logic [3:0] v);
        reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Clear the counter and the flag together; returns the cycle of the clear edge.
    task automatic restart(output int k);
        cnt_clr = 1'b1; flag_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0; flag_clr = 1'b0;
        k = cyc;
    endtask

    task automatic pulse_fclr();
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Driver: program a code, restart and expect one rise one period later.
    task automatic measure(input int code, input string t);
        int k;
        wr({1'b1, 3'(code)});
        restart(k);
        push(k + period(code), t);
        wait_to(k + period(code) + 1);
        chk(reg_rdata[4] == 1'b1, t, reg_rdata[4], 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int k;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(reg_rdata == 5'd0, "R1 rdata", reg_rdata, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);

        // R4 field placement
        wr(4'b1101);
        chk(reg_rdata[3:0] == 4'b1101, "R4 readback", reg_rdata[3:0], 13);
        wr(4'b0011);
        chk(reg_rdata[3:0] == 4'b0011, "R4 readback2", reg_rdata[3:0], 3);

        // R2 short taps, R3 long taps
        for (int c = 0; c < 3; c++) measure(c, "R2 period");
        for (int c = 3; c < 7; c++) measure(c, "R3 period");

        // R8 enable gating with the flag set
        chk(irq == 1'b1, "R8 irq enabled", irq, 1);
        wr(4'b0110);
        chk(irq == 1'b0 && reg_rdata[4], "R8 irq masked", irq, 0);
        wr(4'b1110);
        chk(irq == 1'b1, "R8 irq unmasked", irq, 1);
        pulse_fclr();
        chk(reg_rdata[4] == 1'b0 && irq == 1'b0, "R6 flag cleared", reg_rdata[4], 0);
        repeat (5) @(negedge clk);
        chk(reg_rdata[4] == 1'b0, "R6 stays clear", reg_rdata[4], 0);

        // R5 code 0 in use, code 2 written mid-period
        wr(4'b1000);
        restart(k);
        push(k + 8, "R5 old code boundary");
        push(k + 32, "R5 new code boundary");
        wait_to(k + 2);
        wr(4'b1010);
        wait_to(k + 9);
        pulse_fclr();
        wait_to(k + 33);
        chk(reg_rdata[4] == 1'b1, "R5 flag after new period", reg_rdata[4], 1);

        // R7 clear on the same edge as a period end
        wr(4'b1000);
        restart(k);
        push(k + 8, "R7 set wins");
        wait_to(k + 7);
        pulse_fclr();
        wait_to(k + 9);
        chk(reg_rdata[4] == 1'b1, "R7 flag kept", reg_rdata[4], 1);

        // R9 counter clear keeps the flag and restarts the period
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        k = cyc;
        chk(reg_rdata[4] == 1'b1, "R9 flag untouched", reg_rdata[4], 1);
        pulse_fclr();
        push(k + 8, "R9 restart period");
        wait_to(k + 9);

        // R10 longest period, repeated across the counter wrap
        wr(4'b1111);
        restart(k);
        push(k + period(7), "R10 first");
        push(k + 2 * period(7), "R10 repeat");
        wait_to(k + period(7) + 2);
        pulse_fclr();
        wait_to(k + 2 * period(7) + 1);
        chk(reg_rdata[4] == 1'b1, "R10 flag", reg_rdata[4], 1);

        chk(exp_q.size() == 0, "R2 R3 all expected rises seen", exp_q.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule